// File: doc/BRIEF.md
# Cyclic-Prefix Symbol Timing Correlator

This block recovers OFDM symbol timing from a stream of complex baseband samples by exploiting the repeated cyclic prefix. For every sample it forms the product of that sample with the complex conjugate of the sample one FFT length earlier. It keeps a running sum of these products over a sliding window that is shorter than the prefix. Two running energy sums follow the same window, one over the delayed samples and one over the current samples. No sum is recomputed from scratch: each accepted sample adds the terms that enter the window and subtracts the terms that leave it.

A candidate sample is accepted when its normalised metric, |r|² divided by the product of the two energies, reaches a programmable Q1.15 trigger level. The energy product must also reach a programmable floor, which rejects spurious peaks in near-silent stretches. The division is replaced by a cross-multiplied comparison. Samples are grouped into symbol periods of FFT length plus prefix length, counted from the first sample after reset. Once per period the block emits a one-cycle strobe with the in-period index of the strongest accepted candidate, its complex correlation (for a later frequency-offset estimate) and its energy product.

The sample input is a valid/ready stream. Ready is driven low during reset and held high at all other times, so the block never applies back-pressure. A sample moves only on a cycle where valid and ready are both high, and gaps in valid are allowed anywhere. The result outputs are plain registers qualified by the strobe.

Top module: `cp_sym_timing`

## Requirements
- R1: `s_ready` is low while `rst_n` is low and high from the first rising edge after reset onward, so every sample with `s_valid` high is accepted.
- R2: For accepted sample n, the correlation is the sum over k = n−WIN+1..n of s[k]·conj(s[k−FFT_N]), with samples before the first one after reset taken as zero. The real part is Re·Re+Im·Im and the imaginary part is Im_k·Re_d−Re_k·Im_d.
- R3: The delayed energy sums |s[k−FFT_N]|² and the current energy sums |s[k]|² over the same window. The reported normaliser is their product.
- R4: A sample is a candidate only once FFT_N+WIN samples have been accepted since reset, including itself.
- R5: A candidate passes the trigger when |r|²·2^15 ≥ `thr`·normaliser, with `thr` unsigned Q1.15, so `thr`=0 passes every candidate and a noise-free prefix match gives exactly 1.0.
- R6: A candidate is rejected when its normaliser is below `pwr_floor`.
- R7: Periods are SYM = FFT_N+CP_LEN accepted samples long and start at the first sample after reset. The index reported is the position 0..SYM−1 within the period of the accepted candidate with the largest metric. On equal metrics the earlier one wins.
- R8: `pk_stb` is high for exactly one cycle. It rises on the second rising edge counting the edge that accepted the period's last sample. `pk_idx`, `pk_corr_re`, `pk_corr_im` and `pk_norm` are valid with it and hold until the next strobe.
- R9: A period with no accepted candidate produces no strobe.
- R10: The results depend only on the accepted samples and not on gaps in `s_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, low only in reset |
| s_re | input | 16 | Sample real part, signed |
| s_im | input | 16 | Sample imaginary part, signed |
| thr | input | 16 | Trigger level, unsigned Q1.15 |
| pwr_floor | input | 2·(32+clog2(WIN+1)) | Minimum energy product |
| pk_stb | output | 1 | One-cycle result strobe per period |
| pk_idx | output | clog2(SYM) | In-period index of the best candidate |
| pk_corr_re | output | 33+clog2(WIN+1) | Correlation real part at the best candidate |
| pk_corr_im | output | 33+clog2(WIN+1) | Correlation imaginary part at the best candidate |
| pk_norm | output | 2·(32+clog2(WIN+1)) | Energy product at the best candidate |

## Verification
A sample's window sums are registered on the edge that accepts it. The candidate decision follows on the next edge, so a period's strobe appears one edge after the acceptance of its final sample. The bench records the edge number of every handshake and, for each strobe seen at a falling edge, requires the current edge count to equal that final acceptance edge plus one. Index, correlation and normaliser are compared there against a model that recomputes every window sum directly. Strobe counts per run are checked after the stream has drained for several idle cycles.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int SAMP_W   = 16;
  localparam int THR_W    = 16;
  localparam int THR_FRAC = 15;

  typedef struct packed {
    logic signed [SAMP_W-1:0] re;
    logic signed [SAMP_W-1:0] im;
  } iq_t;

  // |s|^2, at most 2^31
  function automatic logic [31:0] pwr(input iq_t s);
    logic signed [31:0] a;
    logic signed [31:0] b;
    a = 32'(s.re) * 32'(s.re);
    b = 32'(s.im) * 32'(s.im);
    return $unsigned(a) + $unsigned(b);
  endfunction

  // real part of a * conj(b)
  function automatic logic signed [32:0] xc_re(input iq_t a, input iq_t b);
    return 33'(32'(a.re) * 32'(b.re)) + 33'(32'(a.im) * 32'(b.im));
  endfunction

  // imaginary part of a * conj(b)
  function automatic logic signed [32:0] xc_im(input iq_t a, input iq_t b);
    return 33'(32'(a.im) * 32'(b.re)) - 33'(32'(a.re) * 32'(b.im));
  endfunction
endpackage

// File: rtl/cpc_delay.sv
module cpc_delay
  import cpc_pkg::*;
#(
  parameter int FFT_N = 2048,
  parameter int WIN   = 416
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  iq_t  din,
  output iq_t  taps [3],
  output logic full
);
  localparam int DEPTH = FFT_N + WIN;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int DLY [3] = '{FFT_N, WIN, FFT_N + WIN};

  iq_t            mem [DEPTH];
  logic [AW-1:0]  wp;
  logic [CW-1:0]  fill;

  function automatic logic [AW-1:0] back(input logic [AW-1:0] p, input int d);
    int t;
    t = int'(p) - d;
    if (t < 0) t = t + DEPTH;
    return AW'(t);
  endfunction

  // taps read the stored history before this cycle's write; unwritten history reads as zero
  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign taps[g] = (fill >= CW'(DLY[g])) ? mem[back(wp, DLY[g])] : '0;
  end

  assign full = (fill >= CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (adv) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      fill <= '0;
    end else if (adv) begin
      wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/cpc_window.sv
module cpc_window
  import cpc_pkg::*;
#(
  parameter int CORR_W = 42,
  parameter int NRG_W  = 41
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     warm_i,
  input  iq_t                      cur,
  input  iq_t                      dly,
  input  iq_t                      lv_cur,
  input  iq_t                      lv_dly,
  output logic signed [CORR_W-1:0] acc_re,
  output logic signed [CORR_W-1:0] acc_im,
  output logic [NRG_W-1:0]         nrg_dly,
  output logic [NRG_W-1:0]         nrg_cur,
  output logic                     vld,
  output logic                     warm_o
);
  logic signed [CORR_W-1:0] in_re, in_im, out_re, out_im;
  logic [NRG_W-1:0]         in_d, in_c, out_d, out_c;

  assign in_re  = CORR_W'(xc_re(cur, dly));
  assign in_im  = CORR_W'(xc_im(cur, dly));
  assign out_re = CORR_W'(xc_re(lv_cur, lv_dly));
  assign out_im = CORR_W'(xc_im(lv_cur, lv_dly));
  assign in_d   = NRG_W'(pwr(dly));
  assign in_c   = NRG_W'(pwr(cur));
  assign out_d  = NRG_W'(pwr(lv_dly));
  assign out_c  = NRG_W'(pwr(lv_cur));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_re  <= '0;
      acc_im  <= '0;
      nrg_dly <= '0;
      nrg_cur <= '0;
      vld     <= 1'b0;
      warm_o  <= 1'b0;
    end else begin
      vld <= adv;
      if (adv) begin
        acc_re  <= acc_re + in_re - out_re;
        acc_im  <= acc_im + in_im - out_im;
        nrg_dly <= nrg_dly + in_d - out_d;
        nrg_cur <= nrg_cur + in_c - out_c;
        warm_o  <= warm_i;
      end
    end
  end
endmodule

// File: rtl/cpc_peak.sv
module cpc_peak
  import cpc_pkg::*;
#(
  parameter int SYM    = 2560,
  parameter int CORR_W = 42,
  parameter int NRG_W  = 41,
  localparam int NORM_W = 2 * NRG_W,
  localparam int IDX_W  = $clog2(SYM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic                     warm,
  input  logic signed [CORR_W-1:0] acc_re,
  input  logic signed [CORR_W-1:0] acc_im,
  input  logic [NRG_W-1:0]         nrg_dly,
  input  logic [NRG_W-1:0]         nrg_cur,
  input  logic [THR_W-1:0]         thr,
  input  logic [NORM_W-1:0]        floor_v,
  output logic                     stb,
  output logic [IDX_W-1:0]         o_idx,
  output logic signed [CORR_W-1:0] o_re,
  output logic signed [CORR_W-1:0] o_im,
  output logic [NORM_W-1:0]        o_norm
);
  localparam int R2_W  = 2 * CORR_W;
  localparam int CMP_W = R2_W + THR_W + 1;
  localparam int MET_W = R2_W + NORM_W;

  logic signed [R2_W-1:0]   xr, xi;
  logic [R2_W-1:0]          r2;
  logic [NORM_W-1:0]        nrm;
  logic [CMP_W-1:0]         lhs, rhs;
  logic                     pass, better, take, last;

  logic [IDX_W-1:0]         pos;
  logic                     have;
  logic [R2_W-1:0]          b_r2;
  logic [NORM_W-1:0]        b_nrm;
  logic signed [CORR_W-1:0] b_re, b_im;
  logic [IDX_W-1:0]         b_idx;

  assign xr  = R2_W'(acc_re);
  assign xi  = R2_W'(acc_im);
  assign r2  = $unsigned(xr * xr) + $unsigned(xi * xi);
  assign nrm = NORM_W'(nrg_dly) * NORM_W'(nrg_cur);
  assign lhs = CMP_W'(r2) << THR_FRAC;
  assign rhs = CMP_W'(thr) * CMP_W'(nrm);

  assign pass   = warm && (lhs >= rhs) && (nrm >= floor_v);
  assign better = !have || ((MET_W'(r2) * MET_W'(b_nrm)) > (MET_W'(b_r2) * MET_W'(nrm)));
  assign take   = pass && better;
  assign last   = (pos == IDX_W'(SYM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      have   <= 1'b0;
      b_r2   <= '0;
      b_nrm  <= '0;
      b_re   <= '0;
      b_im   <= '0;
      b_idx  <= '0;
      stb    <= 1'b0;
      o_idx  <= '0;
      o_re   <= '0;
      o_im   <= '0;
      o_norm <= '0;
    end else begin
      stb <= 1'b0;
      if (vld) begin
        if (last) begin
          pos  <= '0;
          have <= 1'b0;
          if (have || pass) begin
            stb    <= 1'b1;
            o_idx  <= take ? pos    : b_idx;
            o_re   <= take ? acc_re : b_re;
            o_im   <= take ? acc_im : b_im;
            o_norm <= take ? nrm    : b_nrm;
          end
        end else begin
          pos <= pos + 1'b1;
          if (take) begin
            have  <= 1'b1;
            b_r2  <= r2;
            b_nrm <= nrm;
            b_re  <= acc_re;
            b_im  <= acc_im;
            b_idx <= pos;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cp_sym_timing.sv
module cp_sym_timing
  import cpc_pkg::*;
#(
  parameter int FFT_N  = 2048,
  parameter int CP_LEN = 512,
  parameter int WIN    = 416,
  localparam int SYM    = FFT_N + CP_LEN,
  localparam int NRG_W  = 32 + $clog2(WIN + 1),
  localparam int CORR_W = NRG_W + 1,
  localparam int NORM_W = 2 * NRG_W,
  localparam int IDX_W  = $clog2(SYM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [SAMP_W-1:0] s_re,
  input  logic signed [SAMP_W-1:0] s_im,
  input  logic [THR_W-1:0]         thr,
  input  logic [NORM_W-1:0]        pwr_floor,
  output logic                     pk_stb,
  output logic [IDX_W-1:0]         pk_idx,
  output logic signed [CORR_W-1:0] pk_corr_re,
  output logic signed [CORR_W-1:0] pk_corr_im,
  output logic [NORM_W-1:0]        pk_norm
);
  logic rdy, adv, full, vld, warm;
  iq_t  smp;
  iq_t  taps [3];
  logic signed [CORR_W-1:0] acc_re, acc_im;
  logic [NRG_W-1:0]         nrg_dly, nrg_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= 1'b1;
  end

  assign s_ready = rdy;
  assign adv     = s_valid && rdy;
  assign smp     = {s_re, s_im};

  cpc_delay #(.FFT_N(FFT_N), .WIN(WIN)) u_dly (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(smp), .taps(taps), .full(full)
  );

  cpc_window #(.CORR_W(CORR_W), .NRG_W(NRG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .warm_i(full),
    .cur(smp), .dly(taps[0]), .lv_cur(taps[1]), .lv_dly(taps[2]),
    .acc_re(acc_re), .acc_im(acc_im), .nrg_dly(nrg_dly), .nrg_cur(nrg_cur),
    .vld(vld), .warm_o(warm)
  );

  cpc_peak #(.SYM(SYM), .CORR_W(CORR_W), .NRG_W(NRG_W)) u_pk (
    .clk(clk), .rst_n(rst_n), .vld(vld), .warm(warm),
    .acc_re(acc_re), .acc_im(acc_im), .nrg_dly(nrg_dly), .nrg_cur(nrg_cur),
    .thr(thr), .floor_v(pwr_floor),
    .stb(pk_stb), .o_idx(pk_idx), .o_re(pk_corr_re), .o_im(pk_corr_im), .o_norm(pk_norm)
  );
endmodule

// File: rtl/cp_sym_timing_chk.sv
module cp_sym_timing_chk #(
  parameter int DEPTH = 2464,
  parameter int SYM   = 2560,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             pk_stb,
  input logic [IDX_W-1:0] pk_idx
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] acc_n;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_n <= '0;
    else if (s_valid && s_ready && acc_n != CW'(DEPTH)) acc_n <= acc_n + 1'b1;
  end

  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> s_ready);
  // R4
  warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) pk_stb |-> acc_n == CW'(DEPTH));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) pk_stb |-> pk_idx < IDX_W'(SYM));
  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) pk_stb |=> !pk_stb);
  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) pk_stb |-> $past(s_valid && s_ready, 2));
endmodule

bind cp_sym_timing cp_sym_timing_chk #(.DEPTH(FFT_N + WIN), .SYM(SYM), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .pk_stb(pk_stb), .pk_idx(pk_idx)
);

// File: tb/tb_cp_sym_timing.sv
`timescale 1ns/1ps
module tb_cp_sym_timing;
  localparam int N      = 64;
  localparam int CP     = 16;
  localparam int W      = 12;
  localparam int SYM    = N + CP;
  localparam int NRG_W  = 32 + $clog2(W + 1);
  localparam int CORR_W = NRG_W + 1;
  localparam int NORM_W = 2 * NRG_W;
  localparam int IDX_W  = $clog2(SYM);
  localparam int MAXS   = 8 * SYM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [15:0] s_re = '0, s_im = '0;
  logic [15:0] thr = '0;
  logic [NORM_W-1:0] pwr_floor = '0;
  logic pk_stb;
  logic [IDX_W-1:0] pk_idx;
  logic signed [CORR_W-1:0] pk_corr_re, pk_corr_im;
  logic [NORM_W-1:0] pk_norm;

  always #2 clk = ~clk;

  cp_sym_timing #(.FFT_N(N), .CP_LEN(CP), .WIN(W)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_re(s_re), .s_im(s_im), .thr(thr), .pwr_floor(pwr_floor),
    .pk_stb(pk_stb), .pk_idx(pk_idx), .pk_corr_re(pk_corr_re),
    .pk_corr_im(pk_corr_im), .pk_norm(pk_norm)
  );

  int checks = 0, errors = 0, ecnt = 0, got = 0, exp_n = 0;
  bit mon_en = 0, done = 0;
  int si [MAXS];
  int sq [MAXS];
  int acc_edge [MAXS];
  int e_idx [8];
  int e_last [8];
  longint e_re [8];
  longint e_im [8];
  logic [127:0] e_nrm [8];

  always @(posedge clk) ecnt <= ecnt + 1;

  always @(posedge clk) if (ecnt > 150000 && !done) begin
    errors++;
    $display("FAIL watchdog: edges %0d expected below 150000", ecnt);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int rnd(input int a);
    return int'($urandom % (2 * a + 1)) - a;
  endfunction

  function automatic longint gs(input int k, input bit im);
    if (k < 0) return 0;
    return im ? longint'(sq[k]) : longint'(si[k]);
  endfunction

  // mode 0 clean prefix, 1 prefix plus noise, 2 tiny prefix, 3 noise only
  task automatic gen(input int nsym, input int mode);
    int dr [N];
    int di [N];
    int amp;
    amp = (mode == 2) ? 3 : 1000;
    for (int s = 0; s < nsym; s++) begin
      for (int k = 0; k < N; k++) begin dr[k] = rnd(amp); di[k] = rnd(amp); end
      for (int p = 0; p < SYM; p++) begin
        int src;
        src = (p < CP) ? (N - CP + p) : (p - CP);
        si[s*SYM+p] = (mode == 3) ? rnd(amp) : dr[src];
        sq[s*SYM+p] = (mode == 3) ? rnd(amp) : di[src];
        if (mode == 1) begin
          si[s*SYM+p] += rnd(300);
          sq[s*SYM+p] += rnd(300);
        end
      end
    end
  endtask

  task automatic model(input int total);
    bit have;
    logic [127:0] br2, bnrm;
    longint bre, bim;
    int bidx;
    have = 0; br2 = '0; bnrm = '0; bre = 0; bim = 0; bidx = 0; exp_n = 0;
    for (int n = 0; n < total; n++) begin
      longint cr, ci, d0, d1;
      logic [127:0] r2, nrm;
      bit pass, better;
      cr = 0; ci = 0; d0 = 0; d1 = 0;
      for (int k = n - W + 1; k <= n; k++) begin
        longint ar, ai, br, bi;
        ar = gs(k, 0); ai = gs(k, 1); br = gs(k - N, 0); bi = gs(k - N, 1);
        cr += ar*br + ai*bi;
        ci += ai*br - ar*bi;
        d0 += br*br + bi*bi;
        d1 += ar*ar + ai*ai;
      end
      r2  = 128'(cr*cr + ci*ci);
      nrm = 128'(d0) * 128'(d1);
      pass = (n >= N + W - 1) && ((r2 << 15) >= 128'(thr) * nrm) && (nrm >= 128'(pwr_floor));
      better = !have || (r2 * bnrm > br2 * nrm);
      if (n % SYM == SYM - 1) begin
        if (have || pass) begin
          if (pass && better) begin
            e_idx[exp_n] = n % SYM; e_re[exp_n] = cr; e_im[exp_n] = ci; e_nrm[exp_n] = nrm;
          end else begin
            e_idx[exp_n] = bidx; e_re[exp_n] = bre; e_im[exp_n] = bim; e_nrm[exp_n] = bnrm;
          end
          e_last[exp_n] = n;
          exp_n++;
        end
        have = 0;
      end else if (pass && better) begin
        have = 1; br2 = r2; bnrm = nrm; bre = cr; bim = ci; bidx = n % SYM;
      end
    end
  endtask

  always @(negedge clk) if (mon_en && pk_stb) begin
    if (got >= exp_n) begin
      checks++; errors++;
      $display("FAIL R9 unexpected strobe: idx %0d, expected no strobe", pk_idx);
    end else begin
      checks++;
      if (int'(pk_idx) != e_idx[got]) begin
        errors++; $display("FAIL R7 index: got %0d expected %0d", pk_idx, e_idx[got]);
      end
      checks++;
      if (longint'(pk_corr_re) != e_re[got] || longint'(pk_corr_im) != e_im[got]) begin
        errors++; $display("FAIL R2 correlation: got %0d,%0d expected %0d,%0d",
                           pk_corr_re, pk_corr_im, e_re[got], e_im[got]);
      end
      checks++;
      if (128'(pk_norm) != e_nrm[got]) begin
        errors++; $display("FAIL R3 normaliser: got %0d expected %0d", pk_norm, e_nrm[got]);
      end
      checks++;
      if (ecnt != acc_edge[e_last[got]] + 1) begin
        errors++; $display("FAIL R8 strobe edge: got %0d expected %0d", ecnt, acc_edge[e_last[got]] + 1);
      end
    end
    got++;
  end

  task automatic do_reset();
    rst_n = 1'b0; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (s_ready !== 1'b0 || pk_stb !== 1'b0) begin
      errors++; $display("FAIL R1 reset state: ready %b stb %b expected 0 0", s_ready, pk_stb);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (s_ready !== 1'b1) begin
      errors++; $display("FAIL R1 ready after reset: got %b expected 1", s_ready);
    end
  endtask

  task automatic run(input string tag, input int nsym, input int mode,
                     input logic [15:0] t, input logic [NORM_W-1:0] fl, input bit bub);
    int total;
    total = nsym * SYM;
    thr = t; pwr_floor = fl;
    gen(nsym, mode);
    model(total);
    do_reset();
    got = 0; mon_en = 1;
    for (int n = 0; n < total; n++) begin
      if (bub && ($urandom % 4 == 0)) begin s_valid = 1'b0; @(negedge clk); end
      s_valid = 1'b1; s_re = 16'(si[n]); s_im = 16'(sq[n]);
      acc_edge[n] = ecnt + 1;
      @(negedge clk);
    end
    s_valid = 1'b0;
    repeat (6) @(negedge clk);
    mon_en = 0;
    checks++;
    if (got != exp_n) begin
      errors++; $display("FAIL %s strobe count: got %0d expected %0d", tag, got, exp_n);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R10 clean prefix with gaps in valid; R5 level 0.9
    run("R10", 5, 0, 16'd29491, NORM_W'(1), 1'b1);
    checks++;
    if (exp_n != 5) begin errors++; $display("FAIL R5 clean periods accepted: got %0d expected 5", exp_n); end
    // R5 noisy prefix, level 0.5, continuous stream
    run("R5", 5, 1, 16'd16384, NORM_W'(1), 1'b0);
    // R6 tiny prefix rejected by floor although the level is 0
    run("R6", 4, 2, 16'd0, NORM_W'(64'd1 << 40), 1'b1);
    checks++;
    if (exp_n != 0) begin errors++; $display("FAIL R6 model expects strobes: got %0d expected 0", exp_n); end
    // R4 R7 noise only, every warm candidate accepted
    run("R7", 5, 3, 16'd0, NORM_W'(0), 1'b1);
    checks++;
    if (exp_n < 1 || e_idx[0] < N + W - 1) begin
      errors++; $display("FAIL R4 first index: got %0d expected at least %0d", e_idx[0], N + W - 1);
    end
    // R9 noise only with level near 1.0
    run("R9", 4, 3, 16'd32767, NORM_W'(1), 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule